// File: doc/BRIEF.md
# ADC Auto-Conversion Progress Tracker

This block runs the bookkeeping side of an ADC auto-conversion sequence. It does not model the converter. A trigger input starts a sequence, and a done strobe from the converter marks each finished conversion. In dual mode there are two independent sequencers, A and B, and only one of them may run at a time. In cascaded mode the two are joined into a single sequencer that uses sequencer A's flags and pointer.

All sequencers share one 4-bit down-counter. It is loaded from the maximum-conversion setting when a sequence starts. Each counted conversion moves it one step down and moves the active sequencer's slot pointer one step up.

In simultaneous-sampling mode the converter delivers results in pairs, so one done strobe arrives per sample. The counter and the pointer then move only on the second strobe of each pair. Software reads a packed status word at any time to learn how far the sequence has progressed. The number of units still to go is the counter plus one while the active busy flag is set, and zero when it is clear.

Top module: `adc_seq_tracker`

## Requirements
- R1: After reset, `status`, `busy_a`, `busy_b`, `slot_a` and `slot_b` are all zero.
- R2: `status` holds the counter at bits 11:8, `slot_b` at bits 6:4 and `slot_a` at bits 3:0. Bits 15:12 and bit 7 always read zero.
- R3: A trigger accepted while idle sets that sequencer's busy flag, loads the counter from `max_conv` and clears that sequencer's slot pointer. The result is visible one cycle after the clock edge that samples the trigger.
- R4: Each counted conversion on a busy sequencer does two things. It lowers a nonzero counter by one. It raises the active slot pointer by one, modulo 16 for A and modulo 8 for B.
- R5: A counted conversion with the counter at zero also advances the pointer and then clears the busy flag. The counter stays at zero, and the pointer then holds its value.
- R6: While busy, the units still to go equal the counter plus one. When no sequencer is busy, zero units remain.
- R7: With `simul` high at the accepted trigger, the sequence counts pairs. Only every second done strobe is counted, starting with the second strobe after the trigger. The first strobe of a pair changes no output.
- R8: A trigger on either input while a sequencer is busy changes no output.
- R9: At most one sequencer is busy. If both triggers arrive together in dual mode, sequencer A is started.
- R10: While `cascade` is high, `trig_b` is ignored. Sequencer B's flag and pointer keep their values.
- R11: A done strobe while no sequencer is busy changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_a | input | 1 | Start request for sequencer A (or for the cascaded sequencer) |
| trig_b | input | 1 | Start request for sequencer B, dual mode only |
| conv_done | input | 1 | One-cycle strobe per finished conversion |
| cascade | input | 1 | 1 = cascaded sequencer, 0 = two independent sequencers |
| simul | input | 1 | Simultaneous sampling; captured at the trigger |
| max_conv | input | 4 | Counter load value (conversions or pairs minus one) |
| status | output | 16 | Packed progress word |
| busy_a | output | 1 | Sequencer A (or cascaded) running |
| busy_b | output | 1 | Sequencer B running |
| slot_a | output | 4 | Slot pointer of sequencer A |
| slot_b | output | 3 | Slot pointer of sequencer B |

## Verification
The assertions take for granted that `conv_done` is a single-cycle pulse that arrives only for a conversion that was really started. They also assume that `simul` matters only at the instant of a trigger. The stimulus raises each strobe for exactly one clock and always lowers the triggers before the next cycle. It holds `simul` steady for the whole length of each pair-counting sequence, so the counter checks describe real converter traffic. Where the bench deliberately puts stray strobes and triggers into idle or busy periods, it does so to show that the outputs stay unchanged.

// File: rtl/seqtrk_pkg.sv
package seqtrk_pkg;
    localparam int CNT_W   = 4;
    localparam int SA_W    = 4;
    localparam int SB_W    = 3;
    localparam int STAT_W  = 16;
    localparam int CNT_LSB = 8;
    localparam int SB_LSB  = 4;
    localparam int SA_LSB  = 0;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SA_W-1:0]  slot_a;
        logic [SB_W-1:0]  slot_b;
        logic             busy_a;
        logic             busy_b;
        logic             pairs;
        logic             half;
    } trk_state_t;
endpackage

// File: rtl/seqtrk_arb.sv
module seqtrk_arb (
    input  logic idle,
    input  logic trig_a,
    input  logic trig_b,
    input  logic cascade,
    output logic take_a,
    output logic take_b
);
    always_comb begin
        take_a = idle && trig_a;
        take_b = idle && trig_b && !trig_a && !cascade;
    end
endmodule

// File: rtl/seqtrk_step.sv
module seqtrk_step (
    input  logic busy,
    input  logic done,
    input  logic pairs,
    input  logic half_q,
    output logic step,
    output logic half_d
);
    always_comb begin
        half_d = half_q;
        step   = 1'b0;
        if (busy && done) begin
            if (pairs) begin
                half_d = !half_q;
                step   = half_q;
            end else begin
                step = 1'b1;
            end
        end
    end
endmodule

// File: rtl/adc_seq_tracker.sv
module adc_seq_tracker
    import seqtrk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_a,
    input  logic              trig_b,
    input  logic              conv_done,
    input  logic              cascade,
    input  logic              simul,
    input  logic [CNT_W-1:0]  max_conv,
    output logic [STAT_W-1:0] status,
    output logic              busy_a,
    output logic              busy_b,
    output logic [SA_W-1:0]   slot_a,
    output logic [SB_W-1:0]   slot_b
);
    trk_state_t st_q, st_d;
    logic take_a, take_b, step, half_nx, busy_any;

    assign busy_any = st_q.busy_a || st_q.busy_b;

    seqtrk_arb u_arb (
        .idle    (!busy_any),
        .trig_a  (trig_a),
        .trig_b  (trig_b),
        .cascade (cascade),
        .take_a  (take_a),
        .take_b  (take_b)
    );

    seqtrk_step u_step (
        .busy   (busy_any),
        .done   (conv_done),
        .pairs  (st_q.pairs),
        .half_q (st_q.half),
        .step   (step),
        .half_d (half_nx)
    );

    always_comb begin
        st_d = st_q;
        if (take_a || take_b) begin
            st_d.cnt    = max_conv;
            st_d.pairs  = simul;
            st_d.half   = 1'b0;
            st_d.busy_a = take_a;
            st_d.busy_b = take_b;
            if (take_a) st_d.slot_a = '0;
            else        st_d.slot_b = '0;
        end else begin
            st_d.half = half_nx;
            if (step) begin
                if (st_q.busy_a) st_d.slot_a = st_q.slot_a + 1'b1;
                else             st_d.slot_b = st_q.slot_b + 1'b1;
                if (st_q.cnt == '0) begin
                    st_d.busy_a = 1'b0;
                    st_d.busy_b = 1'b0;
                end else begin
                    st_d.cnt = st_q.cnt - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        status = '0;
        status[CNT_LSB +: CNT_W] = st_q.cnt;
        status[SB_LSB  +: SB_W]  = st_q.slot_b;
        status[SA_LSB  +: SA_W]  = st_q.slot_a;
    end

    assign busy_a = st_q.busy_a;
    assign busy_b = st_q.busy_b;
    assign slot_a = st_q.slot_a;
    assign slot_b = st_q.slot_b;

    // R9
    one_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_a, busy_b}));

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_a || busy_b) && conv_done && !st_q.pairs && status[CNT_LSB +: CNT_W] != '0
        |=> status[CNT_LSB +: CNT_W] == $past(status[CNT_LSB +: CNT_W]) - 1'b1);

    // R5
    seq_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_a || busy_b) && conv_done && !st_q.pairs && status[CNT_LSB +: CNT_W] == '0
        |=> !busy_a && !busy_b);

    // R8
    busy_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_a || busy_b) && (trig_a || trig_b) && !conv_done
        |=> $stable(status) && $stable({busy_a, busy_b}));

    // R10
    cascade_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cascade && !busy_b |=> !busy_b && $stable(slot_b));

    // R11
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_a && !busy_b && !trig_a && !trig_b |=> $stable(status));
endmodule

// File: tb/adc_seq_tracker_test.sv
module adc_seq_tracker_test;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig_a = 1'b0, trig_b = 1'b0, conv_done = 1'b0;
    logic        cascade = 1'b0, simul = 1'b0;
    logic [3:0]  max_conv = '0;
    logic [15:0] status;
    logic        busy_a, busy_b;
    logic [3:0]  slot_a;
    logic [2:0]  slot_b;

    int checks = 0;
    int fails  = 0;
    bit done_all = 0;

    always #2.5 clk = ~clk;

    adc_seq_tracker uut (
        .clk(clk), .rst_n(rst_n), .trig_a(trig_a), .trig_b(trig_b),
        .conv_done(conv_done), .cascade(cascade), .simul(simul),
        .max_conv(max_conv), .status(status), .busy_a(busy_a),
        .busy_b(busy_b), .slot_a(slot_a), .slot_b(slot_b)
    );

    // {ta, tb, done, cas, sim, max[4], cnt[4], slot_a[4], slot_b[3], busy_a, busy_b}
    localparam int NV = 23;
    localparam logic [21:0] VEC [NV] = '{
        {1'b1,1'b0,1'b0,1'b0,1'b0,4'd2, 4'd2,4'd0,3'd0,1'b1,1'b0}, // R3 start A
        {1'b0,1'b0,1'b1,1'b0,1'b0,4'd0, 4'd1,4'd1,3'd0,1'b1,1'b0}, // R4
        {1'b0,1'b1,1'b0,1'b0,1'b0,4'd9, 4'd1,4'd1,3'd0,1'b1,1'b0}, // R8
        {1'b0,1'b0,1'b1,1'b0,1'b0,4'd0, 4'd0,4'd2,3'd0,1'b1,1'b0}, // R4
        {1'b0,1'b0,1'b1,1'b0,1'b0,4'd0, 4'd0,4'd3,3'd0,1'b0,1'b0}, // R5
        {1'b0,1'b0,1'b1,1'b0,1'b0,4'd0, 4'd0,4'd3,3'd0,1'b0,1'b0}, // R11
        {1'b1,1'b1,1'b0,1'b0,1'b0,4'd1, 4'd1,4'd0,3'd0,1'b1,1'b0}, // R9 tie
        {1'b0,1'b0,1'b1,1'b0,1'b0,4'd0, 4'd0,4'd1,3'd0,1'b1,1'b0}, // R4
        {1'b0,1'b0,1'b1,1'b0,1'b0,4'd0, 4'd0,4'd2,3'd0,1'b0,1'b0}, // R5
        {1'b0,1'b1,1'b0,1'b0,1'b0,4'd3, 4'd3,4'd2,3'd0,1'b0,1'b1}, // R3 start B
        {1'b0,1'b0,1'b1,1'b0,1'b0,4'd0, 4'd2,4'd2,3'd1,1'b0,1'b1}, // R4
        {1'b1,1'b0,1'b0,1'b0,1'b0,4'd7, 4'd2,4'd2,3'd1,1'b0,1'b1}, // R8
        {1'b0,1'b0,1'b1,1'b0,1'b0,4'd0, 4'd1,4'd2,3'd2,1'b0,1'b1}, // R4
        {1'b0,1'b0,1'b1,1'b0,1'b0,4'd0, 4'd0,4'd2,3'd3,1'b0,1'b1}, // R4
        {1'b0,1'b0,1'b1,1'b0,1'b0,4'd0, 4'd0,4'd2,3'd4,1'b0,1'b0}, // R5
        {1'b0,1'b1,1'b0,1'b1,1'b0,4'd5, 4'd0,4'd2,3'd4,1'b0,1'b0}, // R10
        {1'b1,1'b0,1'b0,1'b1,1'b0,4'd0, 4'd0,4'd0,3'd4,1'b1,1'b0}, // R3 cascade
        {1'b0,1'b0,1'b1,1'b1,1'b0,4'd0, 4'd0,4'd1,3'd4,1'b0,1'b0}, // R5
        {1'b1,1'b0,1'b0,1'b0,1'b1,4'd1, 4'd1,4'd0,3'd4,1'b1,1'b0}, // R7 start
        {1'b0,1'b0,1'b1,1'b0,1'b1,4'd0, 4'd1,4'd0,3'd4,1'b1,1'b0}, // R7 half
        {1'b0,1'b0,1'b1,1'b0,1'b1,4'd0, 4'd0,4'd1,3'd4,1'b1,1'b0}, // R7 pair
        {1'b0,1'b0,1'b1,1'b0,1'b1,4'd0, 4'd0,4'd1,3'd4,1'b1,1'b0}, // R7 half
        {1'b0,1'b0,1'b1,1'b0,1'b1,4'd0, 4'd0,4'd2,3'd4,1'b0,1'b0}  // R7 end
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic ta, input logic tb, input logic dn,
                       input logic cas, input logic sim, input logic [3:0] mx);
        trig_a = ta; trig_b = tb; conv_done = dn;
        cascade = cas; simul = sim; max_conv = mx;
        @(posedge clk);
        @(negedge clk);
        trig_a = 1'b0; trig_b = 1'b0; conv_done = 1'b0;
    endtask

    function automatic int remaining();
        return (busy_a || busy_b) ? int'(status[11:8]) + 1 : 0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_all) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 status", status, 16'h0);
        chk("R1 busy", {busy_a, busy_b}, 2'b00);
        chk("R1 slots", {slot_a, slot_b}, 7'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            logic [21:0] v;
            logic [15:0] exp_stat;
            v = VEC[i];
            cyc(v[21], v[20], v[19], v[18], v[17], v[16:13]);
            // R2: packing {0000, cnt, 0, slot_b, slot_a}
            exp_stat = {4'b0, v[12:9], 1'b0, v[4:2], v[8:5]};
            chk($sformatf("R2 status vec%0d", i), status, exp_stat);
            chk($sformatf("R9 busy vec%0d", i), {busy_a, busy_b}, v[1:0]);
            chk($sformatf("R2 slot ports vec%0d", i), {slot_a, slot_b}, {v[8:5], v[4:2]});
        end

        // R6: cascaded run of 16 conversions, remaining count after each strobe
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'd15);
        chk("R6 remaining at start", remaining(), 16);
        for (int k = 1; k <= 16; k++) begin
            cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0);
            chk($sformatf("R6 remaining after %0d", k), remaining(), 16 - k);
        end
        // R4: slot A wraps modulo 16
        chk("R4 slot_a wrap", slot_a, 4'd0);
        chk("R5 busy cleared", busy_a, 1'b0);

        // R7: pair counting, 4 pairs from 8 strobes
        cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3);
        chk("R7 pairs at start", remaining(), 4);
        for (int k = 1; k <= 8; k++) begin
            cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd0);
            chk($sformatf("R7 pairs after %0d", k), remaining(), 4 - k / 2);
            chk($sformatf("R7 slot after %0d", k), slot_a, 4'(k / 2));
        end

        // R1: asynchronous reset in mid-sequence
        cyc(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6);
        chk("R3 B started", {busy_b, status[11:8]}, {1'b1, 4'd6});
        rst_n = 1'b0;
        #1;
        chk("R1 mid reset status", status, 16'h0);
        chk("R1 mid reset busy", {busy_a, busy_b}, 2'b00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done_all = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule